// File: doc/BRIEF.md
# Dual Smart Card Signal Router

This block connects host-side control and data lines to the contact sets of two smart cards, A and B. Each card has clock-free control contacts (C4, C8 and reset) and one open-drain data line. In split mode each card has its own set of host lines, and both cards can be driven at the same time. In shared mode only the A-side host lines are used. A card-pick bit then steers those lines to card A or to card B, and the B-side host inputs have no effect.

Each card-side contact output is a register. It takes the host value while the card is reachable, meaning chip select is asserted, transfer mode is active and the card is picked. Otherwise it keeps its value. The data line is modelled as three signals: a card-side line input, a card-side drive-low enable, and a host-side read value. The read value captures the card line while the path is open and keeps its value while the path is closed. A supply-low flag and a card-supply ramp flag are synchronous inputs. While either is high, every card-side output is forced to zero and the stored values are cleared.

Top module: `scr_dual_router`

## Requirements
- R1: Synchronous reset (active high) clears all card-side outputs (C4, C8, reset, data drive enable) to 0 and sets both host read values to RD_RESET (default 1).
- R2: With mux_en = 0, card A follows the A host lines and card B follows the B host lines. Both cards may be updated in the same cycle, and card_pick has no effect.
- R3: With mux_en = 1, the B host inputs are ignored. card_pick = 1 routes the A host lines to card A. card_pick = 0 routes them to card B.
- R4: A card's C4, C8 and reset outputs take their host value one clock later only when chip_sel_n = 0, prog_n = 1 and the card is picked. Otherwise they hold their value. This means a reset request reaches a card only while chip select is asserted.
- R5: A card's data path is open when chip_sel_n = 0 and the card is picked. prog_n does not affect the data path. One clock later, the card-side drive enable equals (path open AND host data = 0), and it is 0 whenever the path is closed.
- R6: Each host read value captures its card line one clock later while that path is open, and holds while it is closed. In shared mode, host_a_io_rd returns the line of the picked card, and host_b_io_rd holds.
- R7: While supply_low or vcc_ramp is 1, all card-side outputs become 0 on the next clock. The cleared values persist after both flags drop, until a new transfer cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mux_en | input | 1 | 1 = shared host lines, 0 = split lines |
| chip_sel_n | input | 1 | Chip select, active low |
| prog_n | input | 1 | 1 = transfer mode, 0 = program mode |
| card_pick | input | 1 | Shared-mode target: 1 = card A, 0 = card B |
| supply_low | input | 1 | Main supply below threshold |
| vcc_ramp | input | 1 | Card supply start-up in progress |
| host_a_c4 | input | 1 | Host C4 for card A (or shared) |
| host_a_c8 | input | 1 | Host C8 for card A (or shared) |
| host_a_rst | input | 1 | Host reset for card A (or shared) |
| host_a_io | input | 1 | Host data drive for card A (0 = pull low) |
| host_a_io_rd | output | 1 | Data seen on card A (or picked card) |
| host_b_c4 | input | 1 | Host C4 for card B |
| host_b_c8 | input | 1 | Host C8 for card B |
| host_b_rst | input | 1 | Host reset for card B |
| host_b_io | input | 1 | Host data drive for card B (0 = pull low) |
| host_b_io_rd | output | 1 | Data seen on card B |
| card_a_c4 | output | 1 | Card A C4 contact |
| card_a_c8 | output | 1 | Card A C8 contact |
| card_a_rst | output | 1 | Card A reset contact |
| card_a_io_oe | output | 1 | Pull card A data line low |
| card_a_io_in | input | 1 | Card A data line level |
| card_b_c4 | output | 1 | Card B C4 contact |
| card_b_c8 | output | 1 | Card B C8 contact |
| card_b_rst | output | 1 | Card B reset contact |
| card_b_io_oe | output | 1 | Pull card B data line low |
| card_b_io_in | input | 1 | Card B data line level |

## Verification
The bench builds the block with its default RD_RESET of 1. This lets it check directly that both host read values come out of reset as an idle-high line, before any data path has opened. A vector table walks split and shared modes through transfer, hold, program-mode and closed-chip-select phases, so the hold behaviour is checked against values stored several steps earlier. Directed steps then raise each supply flag with a transfer pending, check that the cleared values persist after release, and apply a reset mid-run.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int unsigned CARD_CNT = 2;
    localparam int unsigned CARD_A   = 0;
    localparam int unsigned CARD_B   = 1;

    typedef struct packed {
        logic c4;
        logic c8;
        logic rst;
    } contact_t;

    typedef struct packed {
        contact_t ctl;
        logic     io;
    } host_side_t;

    // Whether a card slot is targeted: both in split mode, per pick bit in shared mode.
    function automatic logic card_targeted(input logic mux, input logic pick,
                                           input int unsigned idx);
        if (!mux) return 1'b1;
        return (idx == CARD_A) ? pick : !pick;
    endfunction

    // Open-drain drive: pull the card line only when the path is open and host drives low.
    function automatic logic drive_low(input logic open, input logic host_io);
        return open && !host_io;
    endfunction

endpackage

// File: rtl/scr_steer.sv
module scr_steer
    import scr_pkg::*;
(
    input  logic       mux_en,
    input  logic       card_pick,
    input  host_side_t host_in [CARD_CNT],
    output host_side_t src     [CARD_CNT],
    output logic       picked  [CARD_CNT]
);
    for (genvar g = 0; g < CARD_CNT; g++) begin : g_route
        // In shared mode every slot is fed from the A host lines.
        assign src[g]    = mux_en ? host_in[CARD_A] : host_in[g];
        assign picked[g] = card_targeted(mux_en, card_pick, g);
    end
endmodule

// File: rtl/scr_lane.sv
module scr_lane
    import scr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_fault,
    input  logic       xfer_ok,
    input  logic       path_open,
    input  host_side_t src,
    output contact_t   card_q,
    output logic       io_oe_q
);
    always_ff @(posedge clk) begin
        if (rst || pwr_fault) begin
            card_q  <= '0;
            io_oe_q <= 1'b0;
        end else begin
            if (xfer_ok) card_q <= src.ctl;
            io_oe_q <= drive_low(path_open, src.io);
        end
    end
endmodule

// File: rtl/scr_readback.sv
module scr_readback
    import scr_pkg::*;
#(
    parameter logic RD_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic mux_en,
    input  logic path_open [CARD_CNT],
    input  logic card_line [CARD_CNT],
    output logic rd_q      [CARD_CNT]
);
    logic rd_d [CARD_CNT];

    always_comb begin
        for (int i = 0; i < CARD_CNT; i++) rd_d[i] = rd_q[i];
        if (mux_en) begin
            // Shared mode: the A host port sees whichever card is open.
            for (int i = 0; i < CARD_CNT; i++)
                if (path_open[i]) rd_d[CARD_A] = card_line[i];
        end else begin
            for (int i = 0; i < CARD_CNT; i++)
                if (path_open[i]) rd_d[i] = card_line[i];
        end
    end

    for (genvar g = 0; g < CARD_CNT; g++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) rd_q[g] <= RD_RESET;
            else     rd_q[g] <= rd_d[g];
        end
    end
endmodule

// File: rtl/scr_dual_router.sv
module scr_dual_router
    import scr_pkg::*;
#(
    parameter logic RD_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic mux_en,
    input  logic chip_sel_n,
    input  logic prog_n,
    input  logic card_pick,
    input  logic supply_low,
    input  logic vcc_ramp,
    input  logic host_a_c4,
    input  logic host_a_c8,
    input  logic host_a_rst,
    input  logic host_a_io,
    output logic host_a_io_rd,
    input  logic host_b_c4,
    input  logic host_b_c8,
    input  logic host_b_rst,
    input  logic host_b_io,
    output logic host_b_io_rd,
    output logic card_a_c4,
    output logic card_a_c8,
    output logic card_a_rst,
    output logic card_a_io_oe,
    input  logic card_a_io_in,
    output logic card_b_c4,
    output logic card_b_c8,
    output logic card_b_rst,
    output logic card_b_io_oe,
    input  logic card_b_io_in
);
    host_side_t host_in   [CARD_CNT];
    host_side_t src       [CARD_CNT];
    logic       picked    [CARD_CNT];
    logic       path_open [CARD_CNT];
    logic       card_line [CARD_CNT];
    logic       rd_q      [CARD_CNT];
    contact_t   card_q    [CARD_CNT];
    logic       io_oe_q   [CARD_CNT];
    logic       pwr_fault;

    assign host_in[CARD_A] = '{ctl: '{c4: host_a_c4, c8: host_a_c8, rst: host_a_rst}, io: host_a_io};
    assign host_in[CARD_B] = '{ctl: '{c4: host_b_c4, c8: host_b_c8, rst: host_b_rst}, io: host_b_io};
    assign card_line[CARD_A] = card_a_io_in;
    assign card_line[CARD_B] = card_b_io_in;
    assign pwr_fault = supply_low || vcc_ramp;

    scr_steer i_steer (
        .mux_en    (mux_en),
        .card_pick (card_pick),
        .host_in   (host_in),
        .src       (src),
        .picked    (picked)
    );

    for (genvar g = 0; g < CARD_CNT; g++) begin : g_card
        logic xfer_ok;
        assign path_open[g] = picked[g] && !chip_sel_n;
        assign xfer_ok      = path_open[g] && prog_n;

        scr_lane i_lane (
            .clk       (clk),
            .rst       (rst),
            .pwr_fault (pwr_fault),
            .xfer_ok   (xfer_ok),
            .path_open (path_open[g]),
            .src       (src[g]),
            .card_q    (card_q[g]),
            .io_oe_q   (io_oe_q[g])
        );
    end

    scr_readback #(.RD_RESET(RD_RESET)) i_readback (
        .clk       (clk),
        .rst       (rst),
        .mux_en    (mux_en),
        .path_open (path_open),
        .card_line (card_line),
        .rd_q      (rd_q)
    );

    assign card_a_c4    = card_q[CARD_A].c4;
    assign card_a_c8    = card_q[CARD_A].c8;
    assign card_a_rst   = card_q[CARD_A].rst;
    assign card_a_io_oe = io_oe_q[CARD_A];
    assign card_b_c4    = card_q[CARD_B].c4;
    assign card_b_c8    = card_q[CARD_B].c8;
    assign card_b_rst   = card_q[CARD_B].rst;
    assign card_b_io_oe = io_oe_q[CARD_B];
    assign host_a_io_rd = rd_q[CARD_A];
    assign host_b_io_rd = rd_q[CARD_B];
endmodule

// File: rtl/scr_router_chk.sv
module scr_router_chk (
    input logic clk,
    input logic rst,
    input logic mux_en,
    input logic chip_sel_n,
    input logic prog_n,
    input logic card_pick,
    input logic supply_low,
    input logic vcc_ramp,
    input logic host_a_c4,
    input logic host_a_io,
    input logic host_b_c4,
    input logic host_b_io_rd,
    input logic card_a_c4,
    input logic card_a_c8,
    input logic card_a_rst,
    input logic card_a_io_oe,
    input logic card_b_c4,
    input logic card_b_c8,
    input logic card_b_rst,
    input logic card_b_io_oe
);
    // R7
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (supply_low || vcc_ramp) |=>
        !(card_a_c4 || card_a_c8 || card_a_rst || card_a_io_oe ||
          card_b_c4 || card_b_c8 || card_b_rst || card_b_io_oe));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_sel_n && !supply_low && !vcc_ramp) |=>
        ($stable(card_a_c4) && $stable(card_a_rst) && $stable(card_b_c4) && $stable(card_b_rst)));

    // R5
    oe_closed_chk: assert property (@(posedge clk) disable iff (rst)
        chip_sel_n |=> (!card_a_io_oe && !card_b_io_oe));

    // R3
    mux_route_b_chk: assert property (@(posedge clk) disable iff (rst)
        (mux_en && !card_pick && !chip_sel_n && prog_n && !supply_low && !vcc_ramp) |=>
        (card_b_c4 == $past(host_a_c4)) && $stable(card_a_c4));

    // R2
    split_route_chk: assert property (@(posedge clk) disable iff (rst)
        (!mux_en && !chip_sel_n && prog_n && !supply_low && !vcc_ramp) |=>
        (card_b_c4 == $past(host_b_c4)) && (card_a_c4 == $past(host_a_c4)));

    // R6
    shared_b_rd_chk: assert property (@(posedge clk) disable iff (rst)
        mux_en |=> $stable(host_b_io_rd));
endmodule

bind scr_dual_router scr_router_chk i_chk (.*);

// File: tb/test_scr_dual_router.sv
module test_scr_dual_router;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mux_en = 0, chip_sel_n = 1, prog_n = 1, card_pick = 1;
    logic supply_low = 0, vcc_ramp = 0;
    logic host_a_c4 = 0, host_a_c8 = 0, host_a_rst = 0, host_a_io = 1;
    logic host_b_c4 = 0, host_b_c8 = 0, host_b_rst = 0, host_b_io = 1;
    logic card_a_io_in = 1, card_b_io_in = 1;
    logic host_a_io_rd, host_b_io_rd;
    logic card_a_c4, card_a_c8, card_a_rst, card_a_io_oe;
    logic card_b_c4, card_b_c8, card_b_rst, card_b_io_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    scr_dual_router i_scr_dual_router (.*);

    // {a_c4,a_c8,a_rst,a_oe, b_c4,b_c8,b_rst,b_oe, rd_a, rd_b}
    logic [9:0] obs;
    assign obs = {card_a_c4, card_a_c8, card_a_rst, card_a_io_oe,
                  card_b_c4, card_b_c8, card_b_rst, card_b_io_oe,
                  host_a_io_rd, host_b_io_rd};

    // {mux, cs_n, prog_n, pick, A c4 c8 rst io, B c4 c8 rst io, lineA, lineB, 2'b0}
    localparam logic [15:0] STIM [10] = '{
        16'b0011_1011_0110_0100,
        16'b0101_0100_1001_1000,
        16'b0000_0100_1001_1000,
        16'b0010_0100_1001_1000,
        16'b1011_1111_0000_0100,
        16'b1010_0110_1101_1100,
        16'b1110_1001_0010_0000,
        16'b1001_0000_1111_1000,
        16'b1011_0001_1111_0100,
        16'b0011_1011_0001_1000
    };
    localparam logic [9:0] EXPV [10] = '{
        10'b1010_0111_01,
        10'b1010_0110_01,
        10'b1011_0110_10,
        10'b0101_1000_10,
        10'b1110_1000_00,
        10'b1110_0111_10,
        10'b1110_0110_10,
        10'b1111_0110_10,
        10'b0000_0110_00,
        10'b1010_0000_10
    };
    localparam string ROW_REQ [10] = '{
        "R2 split both cards", "R4 hold with chip select off",
        "R5 program mode opens data only", "R2 pick ignored in split",
        "R3 shared to A", "R3 shared to B, B lines ignored",
        "R6 read hold in shared", "R5 drive low in program mode",
        "R3 shared back to A", "R2 split return"
    };

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] s);
        {mux_en, chip_sel_n, prog_n, card_pick,
         host_a_c4, host_a_c8, host_a_rst, host_a_io,
         host_b_c4, host_b_c8, host_b_rst, host_b_io,
         card_a_io_in, card_b_io_in} = s[15:2];
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step; step;
        // R1: reset state
        check("R1 reset state", obs, 10'b0000_0000_11);
        rst = 1'b0;

        for (int i = 0; i < 10; i++) begin
            apply(STIM[i]);
            step;
            check(ROW_REQ[i], obs, EXPV[i]);
        end

        // R7: supply low with a transfer pending clears everything
        apply(16'b0011_1110_1110_0000);
        supply_low = 1'b1;
        step;
        check("R7 supply low forces zero", obs[9:2], 8'b0);
        // R7: cleared values persist after release while chip select is off
        supply_low = 1'b0;
        chip_sel_n = 1'b1;
        step;
        check("R7 cleared values held", obs[9:2], 8'b0);
        // R7: ramp flag forces zero
        chip_sel_n = 1'b0;
        vcc_ramp = 1'b1;
        step;
        check("R7 ramp forces zero", obs[9:2], 8'b0);
        // R7/R2: recovery after ramp ends
        vcc_ramp = 1'b0;
        step;
        check("R7 recovery transfer", obs[9:2], 8'b1111_1111);

        // R4: reset contact is not passed while chip select is off
        chip_sel_n = 1'b1;
        host_a_rst = 1'b0;
        host_b_rst = 1'b0;
        step;
        check("R4 reset gated by chip select", {card_a_rst, card_b_rst}, 2'b11);

        // R1: reset mid-run
        rst = 1'b1;
        step;
        check("R1 reset mid-run", obs, 10'b0000_0000_11);
        rst = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule